// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Block

This block holds the software-visible configuration and status state of a four-bank SDRAM controller, together with the address decoder that the bank settings drive. Software reaches every register through a two-entry window. A write to the pointer port selects an internal register offset. Reads and writes on the data port then act on the selected register. Each register applies its own write mask. The error status registers are cleared by writing ones. The status register cannot be written; it records changes of the global enable and of the self-refresh request bit. A write to the ECC error status register drives a level interrupt.

Each bank register holds three fields: a base address, a power-of-two size code and an enable bit. The decoder compares every incoming memory address against the banks that are live. A bank is live only when its own enable and the global enable are both set. The decoder reports whether any bank was hit, which bank it was (the lowest index wins on overlap), and the offset inside that bank.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write with acc_port=0 loads acc_wdata[7:0] into the offset pointer. A read with acc_port=0 returns the pointer zero-extended. With acc_port=1, a write (acc_valid=1, acc_write=1) updates the register at the pointer offset on the next clock edge. acc_rdata combinationally shows that register.
- R2: After reset: config (0x20) = 0x00800000, refresh (0x30) = 0x05F00000, power timer (0x34) = 0x07C00000, timing (0x80) = 0x00854009, and every other offset reads 0. ecc_irq=0, and the decoder reports no hit.
- R3: Offsets outside the map {0x00,0x08,0x10,0x20,0x24,0x30,0x34,0x40,0x44,0x48,0x4C,0x80,0x94,0x98} read 0, and writes to them change nothing. Writes to status (0x24) are ignored.
- R4: A config write that takes bit 31 from 0 to 1 clears status bit 31. A config write that takes bit 31 from 1 to 0 sets it. Otherwise status bit 31 keeps its value, so after reset it reads 0 although config bit 31 is 0.
- R5: A config write that takes bit 30 from 0 to 1 sets status bit 30. A write that takes it from 1 to 0 clears status bit 30. Otherwise status bit 30 is unchanged. Config stores the full written word.
- R6: Stored values are: refresh = data & 0x3FF80000; timing = data & 0x018FC01F; ECC config (0x94) = data & 0x00F00000; power timer = (data & 0xF8000000) | 0x07C00000.
- R7: Writing to error status 0 (0x00) or error status 1 (0x08) clears the bits written as one. Error address (0x10) and ECC error status (0x98) store the full word.
- R8: A write to 0x98 that takes it from zero to non-zero sets ecc_irq. A write that takes it from non-zero to zero clears ecc_irq. No other access changes ecc_irq.
- R9: Bank registers sit at 0x40 + 4*n. A write is stored as data & 0xFFDEE001. Base = bits 31:23 (8 MiB units), size code = bits 19:17 with size = 4 MiB << code (code 7 = 512 MiB), enable = bit 0.
- R10: Bank n matches an address when its enable bit is set, config bit 31 is set, and (address & ~(size-1)) == (base & ~(size-1)).
- R11: On a match dec_hit=1, dec_bank = the bank index and dec_offset = address & (size-1). With no match all three are 0.
- R12: When several banks match, the lowest-numbered bank is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, qualified by acc_valid |
| acc_port | input | 1 | 0 = offset pointer, 1 = data window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected port |
| ecc_irq | output | 1 | ECC error interrupt level |
| dec_addr | input | 32 | Memory address to decode |
| dec_hit | output | 1 | Some live bank covers dec_addr |
| dec_bank | output | 2 | Index of the winning bank |
| dec_offset | output | 32 | Offset of dec_addr inside that bank |

## Verification
The assertions assume that software reaches the data port only after the pointer has been loaded. They also assume that acc_write is meaningful only while acc_valid is high. They take the global enable and ecc_irq to move only in response to data-port writes. The stimulus satisfies these assumptions: every access is a full pointer-then-data pair, and all inputs change on the falling edge. The decode sweeps walk the whole 4 GiB space in 4 MiB steps. At each step they probe the last byte below the boundary and one point inside the step, across bank layouts that overlap, that have a misaligned base, and that use the largest size code.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

    localparam int WORD_W = 32;

    localparam logic [7:0] OFS_ERR0  = 8'h00;
    localparam logic [7:0] OFS_ERR1  = 8'h08;
    localparam logic [7:0] OFS_EADR  = 8'h10;
    localparam logic [7:0] OFS_CFG   = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h24;
    localparam logic [7:0] OFS_RFSH  = 8'h30;
    localparam logic [7:0] OFS_PTMR  = 8'h34;
    localparam logic [7:0] OFS_BANK0 = 8'h40;
    localparam int         BANK_STEP = 4;
    localparam logic [7:0] OFS_TIME  = 8'h80;
    localparam logic [7:0] OFS_ECFG  = 8'h94;
    localparam logic [7:0] OFS_EERR  = 8'h98;

    localparam logic [WORD_W-1:0] MSK_RFSH = 32'h3FF8_0000;
    localparam logic [WORD_W-1:0] MSK_TIME = 32'h018F_C01F;
    localparam logic [WORD_W-1:0] MSK_ECFG = 32'h00F0_0000;
    localparam logic [WORD_W-1:0] MSK_PTMR = 32'hF800_0000;
    localparam logic [WORD_W-1:0] SET_PTMR = 32'h07C0_0000;
    localparam logic [WORD_W-1:0] MSK_BANK = 32'hFFDE_E001;

    localparam logic [WORD_W-1:0] RST_CFG  = 32'h0080_0000;
    localparam logic [WORD_W-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [WORD_W-1:0] RST_PTMR = 32'h07C0_0000;
    localparam logic [WORD_W-1:0] RST_TIME = 32'h0085_4009;

    localparam int BASE_LSB = 23;
    localparam int BASE_W   = WORD_W - BASE_LSB;
    localparam int CODE_LSB = 17;
    localparam int CODE_W   = 3;
    localparam logic [WORD_W-1:0] MIN_BANK_BYTES = 32'h0040_0000;

    function automatic logic [WORD_W-1:0] bank_bytes(input logic [CODE_W-1:0] code);
        return MIN_BANK_BYTES << code;
    endfunction

endpackage

// File: rtl/sdcfg_regfile.sv
module sdcfg_regfile
    import sdcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int OFS_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic                        acc_port,
    input  logic [WORD_W-1:0]           acc_wdata,
    output logic [WORD_W-1:0]           acc_rdata,
    output logic                        ecc_irq,
    output logic                        glb_en,
    output logic [NUM_BANKS-1:0]        bank_en,
    output logic [NUM_BANKS*BASE_W-1:0] bank_base,
    output logic [NUM_BANKS*CODE_W-1:0] bank_code,
    output logic [OFS_W-1:0]            cur_ofs
);

    typedef struct packed {
        logic [OFS_W-1:0]                  ptr;
        logic [WORD_W-1:0]                 err0;
        logic [WORD_W-1:0]                 err1;
        logic [WORD_W-1:0]                 eadr;
        logic [WORD_W-1:0]                 cfg;
        logic [WORD_W-1:0]                 stat;
        logic [WORD_W-1:0]                 rfsh;
        logic [WORD_W-1:0]                 ptmr;
        logic [WORD_W-1:0]                 tmg;
        logic [WORD_W-1:0]                 ecfg;
        logic [WORD_W-1:0]                 eerr;
        logic                              irq;
        logic [NUM_BANKS-1:0][WORD_W-1:0]  bank;
    } regs_t;

    regs_t st_q, st_d;
    logic  wr_ptr, wr_dat;

    assign wr_ptr = acc_valid && acc_write && !acc_port;
    assign wr_dat = acc_valid && acc_write && acc_port;

    always_comb begin
        st_d = st_q;
        if (wr_ptr) begin
            st_d.ptr = acc_wdata[OFS_W-1:0];
        end
        if (wr_dat) begin
            case (st_q.ptr)
                OFS_W'(OFS_ERR0): st_d.err0 = st_q.err0 & ~acc_wdata;
                OFS_W'(OFS_ERR1): st_d.err1 = st_q.err1 & ~acc_wdata;
                OFS_W'(OFS_EADR): st_d.eadr = acc_wdata;
                OFS_W'(OFS_CFG): begin
                    st_d.cfg = acc_wdata;
                    if (!st_q.cfg[31] && acc_wdata[31]) st_d.stat[31] = 1'b0;
                    else if (st_q.cfg[31] && !acc_wdata[31]) st_d.stat[31] = 1'b1;
                    if (!st_q.cfg[30] && acc_wdata[30]) st_d.stat[30] = 1'b1;
                    else if (st_q.cfg[30] && !acc_wdata[30]) st_d.stat[30] = 1'b0;
                end
                OFS_W'(OFS_RFSH): st_d.rfsh = acc_wdata & MSK_RFSH;
                OFS_W'(OFS_PTMR): st_d.ptmr = (acc_wdata & MSK_PTMR) | SET_PTMR;
                OFS_W'(OFS_TIME): st_d.tmg  = acc_wdata & MSK_TIME;
                OFS_W'(OFS_ECFG): st_d.ecfg = acc_wdata & MSK_ECFG;
                OFS_W'(OFS_EERR): begin
                    st_d.eerr = acc_wdata;
                    if (st_q.eerr == '0 && acc_wdata != '0) st_d.irq = 1'b1;
                    else if (st_q.eerr != '0 && acc_wdata == '0) st_d.irq = 1'b0;
                end
                default: ;
            endcase
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (st_q.ptr == OFS_W'(int'(OFS_BANK0) + BANK_STEP * i)) begin
                    st_d.bank[i] = acc_wdata & MSK_BANK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= RST_CFG;
            st_q.rfsh <= RST_RFSH;
            st_q.ptmr <= RST_PTMR;
            st_q.tmg  <= RST_TIME;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (!acc_port) begin
            acc_rdata = WORD_W'(st_q.ptr);
        end else begin
            case (st_q.ptr)
                OFS_W'(OFS_ERR0): acc_rdata = st_q.err0;
                OFS_W'(OFS_ERR1): acc_rdata = st_q.err1;
                OFS_W'(OFS_EADR): acc_rdata = st_q.eadr;
                OFS_W'(OFS_CFG):  acc_rdata = st_q.cfg;
                OFS_W'(OFS_STAT): acc_rdata = st_q.stat;
                OFS_W'(OFS_RFSH): acc_rdata = st_q.rfsh;
                OFS_W'(OFS_PTMR): acc_rdata = st_q.ptmr;
                OFS_W'(OFS_TIME): acc_rdata = st_q.tmg;
                OFS_W'(OFS_ECFG): acc_rdata = st_q.ecfg;
                OFS_W'(OFS_EERR): acc_rdata = st_q.eerr;
                default: ;
            endcase
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (st_q.ptr == OFS_W'(int'(OFS_BANK0) + BANK_STEP * i)) begin
                    acc_rdata = st_q.bank[i];
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_bank_out
            assign bank_en[g]                     = st_q.bank[g][0];
            assign bank_base[g*BASE_W +: BASE_W]  = st_q.bank[g][WORD_W-1:BASE_LSB];
            assign bank_code[g*CODE_W +: CODE_W]  = st_q.bank[g][CODE_LSB +: CODE_W];
        end
    endgenerate

    assign ecc_irq = st_q.irq;
    assign glb_en  = st_q.cfg[31];
    assign cur_ofs = st_q.ptr;

endmodule

// File: rtl/sdcfg_bank_dec.sv
module sdcfg_bank_dec
    import sdcfg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        glb_en,
    input  logic [NUM_BANKS-1:0]        bank_en,
    input  logic [NUM_BANKS*BASE_W-1:0] bank_base,
    input  logic [NUM_BANKS*CODE_W-1:0] bank_code,
    input  logic [WORD_W-1:0]           dec_addr,
    output logic                        dec_hit,
    output logic [IDX_W-1:0]            dec_bank,
    output logic [WORD_W-1:0]           dec_offset
);

    logic [NUM_BANKS-1:0] match;
    logic [WORD_W-1:0]    low_mask [NUM_BANKS];

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_cmp
            logic [WORD_W-1:0] base_addr;
            assign base_addr   = {bank_base[g*BASE_W +: BASE_W], {BASE_LSB{1'b0}}};
            assign low_mask[g] = bank_bytes(bank_code[g*CODE_W +: CODE_W]) - 1'b1;
            assign match[g]    = glb_en && bank_en[g] &&
                                 ((dec_addr & ~low_mask[g]) == (base_addr & ~low_mask[g]));
        end
    endgenerate

    always_comb begin
        dec_hit    = 1'b0;
        dec_bank   = '0;
        dec_offset = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                dec_hit    = 1'b1;
                dec_bank   = IDX_W'(i);
                dec_offset = dec_addr & low_mask[i];
            end
        end
    end

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdcfg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_port,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic [WORD_W-1:0] acc_rdata,
    output logic              ecc_irq,
    input  logic [WORD_W-1:0] dec_addr,
    output logic              dec_hit,
    output logic [IDX_W-1:0]  dec_bank,
    output logic [WORD_W-1:0] dec_offset
);

    localparam int OFS_W = 8;

    logic                        glb_en;
    logic [NUM_BANKS-1:0]        bank_en;
    logic [NUM_BANKS*BASE_W-1:0] bank_base;
    logic [NUM_BANKS*CODE_W-1:0] bank_code;
    logic [OFS_W-1:0]            cur_ofs;

    sdcfg_regfile #(.NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_port  (acc_port),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .ecc_irq   (ecc_irq),
        .glb_en    (glb_en),
        .bank_en   (bank_en),
        .bank_base (bank_base),
        .bank_code (bank_code),
        .cur_ofs   (cur_ofs)
    );

    sdcfg_bank_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .glb_en     (glb_en),
        .bank_en    (bank_en),
        .bank_base  (bank_base),
        .bank_code  (bank_code),
        .dec_addr   (dec_addr),
        .dec_hit    (dec_hit),
        .dec_bank   (dec_bank),
        .dec_offset (dec_offset)
    );

endmodule

// File: rtl/sdcfg_checker.sv
module sdcfg_checker
    import sdcfg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic                 acc_port,
    input logic [WORD_W-1:0]    acc_wdata,
    input logic                 ecc_irq,
    input logic                 dec_hit,
    input logic [IDX_W-1:0]     dec_bank,
    input logic [WORD_W-1:0]    dec_offset,
    input logic                 glb_en,
    input logic [NUM_BANKS-1:0] bank_en,
    input logic [7:0]           cur_ofs
);

    logic wr_eerr, wr_cfg;
    assign wr_eerr = acc_valid && acc_write && acc_port && (cur_ofs == OFS_EERR);
    assign wr_cfg  = acc_valid && acc_write && acc_port && (cur_ofs == OFS_CFG);

    // R8: irq rises after a non-zero ECC error status write
    a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eerr && acc_wdata != '0) |=> ecc_irq);

    // R8: irq falls after a zero ECC error status write
    a_r8_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eerr && acc_wdata == '0) |=> !ecc_irq);

    // R8: no other access moves the irq
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_eerr |=> $stable(ecc_irq));

    // R4: global enable moves only after a config write
    a_r4_glb_move: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(glb_en));

    // R10: a reported hit belongs to a live bank
    a_r10_hit_live: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (glb_en && bank_en[dec_bank]));

    // R11: a miss reports zero bank and zero offset
    a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_bank == '0 && dec_offset == '0));

endmodule

bind sdram_cfg_regs sdcfg_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_port   (acc_port),
    .acc_wdata  (acc_wdata),
    .ecc_irq    (ecc_irq),
    .dec_hit    (dec_hit),
    .dec_bank   (dec_bank),
    .dec_offset (dec_offset),
    .glb_en     (glb_en),
    .bank_en    (bank_en),
    .cur_ofs    (cur_ofs)
);

// File: tb/sim_sdram_cfg_regs.sv
module sim_sdram_cfg_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_port = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        ecc_irq;
    logic [31:0] dec_addr = '0;
    logic        dec_hit;
    logic [1:0]  dec_bank;
    logic [31:0] dec_offset;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [31:0] mdl [256];
    logic        exp_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cfg_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_port   (acc_port),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .ecc_irq    (ecc_irq),
        .dec_addr   (dec_addr),
        .dec_hit    (dec_hit),
        .dec_bank   (dec_bank),
        .dec_offset (dec_offset)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic put(input logic port, input logic [31:0] v);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_port = port; acc_wdata = v;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] o, output logic [31:0] v);
        put(1'b0, {24'h0, o});
        acc_port = 1'b1;
        #1 v = acc_rdata;
    endtask

    function automatic bit is_mapped(input int o);
        case (o)
            'h00, 'h08, 'h10, 'h20, 'h24, 'h30, 'h34, 'h40, 'h44, 'h48, 'h4C,
            'h80, 'h94, 'h98: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // write through the window while updating the bench model from the requirements
    task automatic wr_m(input logic [7:0] o, input logic [31:0] v);
        logic [31:0] c;
        c = mdl['h20];
        case (o)
            8'h00, 8'h08: mdl[o] = mdl[o] & ~v;
            8'h10: mdl[o] = v;
            8'h98: begin mdl[o] = v; exp_irq = (v != 0); end
            8'h20: begin
                if (!c[31] && v[31]) mdl['h24][31] = 1'b0;
                if (c[31] && !v[31]) mdl['h24][31] = 1'b1;
                if (!c[30] && v[30]) mdl['h24][30] = 1'b1;
                if (c[30] && !v[30]) mdl['h24][30] = 1'b0;
                mdl[o] = v;
            end
            8'h30: mdl[o] = v & 32'h3FF80000;
            8'h34: mdl[o] = (v & 32'hF8000000) | 32'h07C00000;
            8'h80: mdl[o] = v & 32'h018FC01F;
            8'h94: mdl[o] = v & 32'h00F00000;
            8'h40, 8'h44, 8'h48, 8'h4C: mdl[o] = v & 32'hFFDEE001;
            default: ;
        endcase
        put(1'b0, {24'h0, o});
        put(1'b1, v);
    endtask

    task automatic verify_all(input string tag);
        logic [31:0] r;
        for (int o = 0; o < 256; o++) begin
            rreg(o[7:0], r);
            chk(r == mdl[o], $sformatf("%s ofs %02h", tag, o), r, mdl[o]);
        end
    endtask

    function automatic void mdl_dec(input logic [31:0] a, output logic h,
                                    output logic [1:0] b, output logic [31:0] ofs);
        h = 1'b0; b = '0; ofs = '0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] bc;
            longint sz, base;
            bc   = mdl['h40 + 4*i];
            sz   = longint'(4194304) << bc[19:17];
            base = longint'(bc[31:23]) * 8388608;
            if (!h && mdl['h20][31] && bc[0] && (longint'(a) / sz == base / sz)) begin
                h = 1'b1; b = i[1:0]; ofs = 32'(longint'(a) % sz);
            end
        end
    endfunction

    task automatic sweep(input string tag);
        logic h; logic [1:0] b; logic [31:0] o, a;
        acc_port = 1'b1;
        for (int k = 0; k < 1024; k++) begin
            for (int j = 0; j < 2; j++) begin
                a = (j == 0) ? (32'(k) * 32'h0040_0000 + ((32'(k) * 32'h1357) & 32'h003F_FFFF))
                             : (32'(k) * 32'h0040_0000 - 32'h1);
                @(negedge clk);
                dec_addr = a;
                #1;
                mdl_dec(a, h, b, o);
                chk(dec_hit == h && dec_bank == b && dec_offset == o,
                    $sformatf("%s addr %08h hit/bank", tag, a),
                    {dec_hit, 29'h0, dec_bank} ^ dec_offset, {h, 29'h0, b} ^ o);
            end
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
        pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
        for (int o = 0; o < 256; o++) mdl[o] = '0;
        mdl['h20] = 32'h0080_0000; mdl['h30] = 32'h05F0_0000;
        mdl['h34] = 32'h07C0_0000; mdl['h80] = 32'h0085_4009;
        exp_irq = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        #1;
        chk(ecc_irq == 1'b0, "R2 irq after reset", {31'h0, ecc_irq}, 32'h0);
        chk(dec_hit == 1'b0, "R2 no hit after reset", {31'h0, dec_hit}, 32'h0);
        verify_all("R2 reset value");

        // R1: pointer port
        put(1'b0, 32'hFFFF_FF34);
        acc_port = 1'b0; #1;
        chk(acc_rdata == 32'h34, "R1 pointer readback", acc_rdata, 32'h34);
        acc_port = 1'b1; #1;
        chk(acc_rdata == 32'h07C0_0000, "R1 data window", acc_rdata, 32'h07C0_0000);

        // R3: unmapped offsets and status are write-ignored
        for (int o = 0; o < 256; o++) begin
            if (!is_mapped(o)) begin
                wr_m(o[7:0], 32'hFFFF_FFFF);
                acc_port = 1'b1; #1;
                chk(acc_rdata == 32'h0, $sformatf("R3 unmapped %02h", o), acc_rdata, 32'h0);
            end
        end
        wr_m(8'h24, 32'hFFFF_FFFF);
        verify_all("R3 no side effect");

        // R6: write masks
        foreach (pats[p]) begin
            wr_m(8'h30, pats[p]); wr_m(8'h34, pats[p]);
            wr_m(8'h80, pats[p]); wr_m(8'h94, pats[p]);
            rreg(8'h30, r); chk(r == mdl['h30], "R6 refresh mask", r, mdl['h30]);
            rreg(8'h34, r); chk(r == mdl['h34], "R6 power timer", r, mdl['h34]);
            rreg(8'h80, r); chk(r == mdl['h80], "R6 timing mask", r, mdl['h80]);
            rreg(8'h94, r); chk(r == mdl['h94], "R6 ecc cfg mask", r, mdl['h94]);
        end

        // R7: clear-on-one and plain registers
        wr_m(8'h00, 32'hFFFF_FFFF); rreg(8'h00, r); chk(r == 0, "R7 err0 w1c", r, 0);
        wr_m(8'h08, 32'h0000_FFFF); rreg(8'h08, r); chk(r == 0, "R7 err1 w1c", r, 0);
        wr_m(8'h10, 32'h1234_5678); rreg(8'h10, r); chk(r == 32'h1234_5678, "R7 err addr", r, 32'h1234_5678);

        // R4 / R5: status tracking of config transitions
        begin
            logic [31:0] seq [6];
            seq[0] = 32'h8000_0000; seq[1] = 32'h0000_0000; seq[2] = 32'hC000_0000;
            seq[3] = 32'h4000_0000; seq[4] = 32'h0000_0000; seq[5] = 32'h0000_0000;
            foreach (seq[s]) begin
                wr_m(8'h20, seq[s]);
                rreg(8'h24, r);
                chk(r == mdl['h24], $sformatf("R4 R5 status step %0d", s), r, mdl['h24]);
                rreg(8'h20, r);
                chk(r == mdl['h20], $sformatf("R5 config store step %0d", s), r, mdl['h20]);
            end
        end

        // R8: ECC error interrupt
        begin
            logic [31:0] ev [5];
            logic [7:0]  eo [5];
            eo[0] = 8'h98; ev[0] = 32'h5;
            eo[1] = 8'h98; ev[1] = 32'h3;
            eo[2] = 8'h30; ev[2] = 32'h0;
            eo[3] = 8'h98; ev[3] = 32'h0;
            eo[4] = 8'h98; ev[4] = 32'h0;
            foreach (ev[s]) begin
                wr_m(eo[s], ev[s]);
                #1;
                chk(ecc_irq == exp_irq, $sformatf("R8 irq step %0d", s), {31'h0, ecc_irq}, {31'h0, exp_irq});
            end
            rreg(8'h98, r); chk(r == 0, "R7 ecc err readback", r, 0);
        end

        // R9: bank field mask
        wr_m(8'h48, 32'hFFFF_FFFF); rreg(8'h48, r);
        chk(r == 32'hFFDE_E001, "R9 bank mask", r, 32'hFFDE_E001);

        // R10: banks enabled but global enable off
        wr_m(8'h20, 32'h0000_0000);
        wr_m(8'h40, 32'h0004_0001);
        wr_m(8'h44, 32'h0102_0001);
        wr_m(8'h48, 32'h0080_0001);
        wr_m(8'h4C, 32'h800C_0001);
        sweep("R10 global off");

        // R10 R11 R12: global on, bank 2 shadowed by bank 0
        wr_m(8'h20, 32'h8000_0000);
        sweep("R12 overlap");

        // R11: bank 0 disabled exposes bank 2
        wr_m(8'h40, 32'h0004_0000);
        sweep("R11 bank0 off");

        // R9 R10: largest code and a misaligned base
        wr_m(8'h4C, 32'h800E_0001);
        wr_m(8'h44, 32'h0184_0001);
        sweep("R9 code7 misaligned");

        verify_all("R3 final state");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule